// File: doc/BRIEF.md
# Host-Coprocessor Mailbox Register Interface

This block is the register window through which a host processor talks to an embedded coprocessor. A host bus with byte addresses reaches a control register (coprocessor hold and clock gate), two doorbell registers (host-to-coprocessor and coprocessor-to-host) and a five-word message RAM. A second port on the coprocessor side reads the host doorbell and the message RAM, and writes the message RAM and the return doorbell.

A built-in sequencer performs the two host jobs that need exact ordering. The first is a command transaction: it writes a checksummed frame, rings the doorbell, polls for a nonzero reply with a cycle-count timeout, reads the reply frame back and clears the return doorbell. It then reports one error class on a 5-bit status. The second is an enable sequence that releases the coprocessor in three separate steps. While the sequencer is busy it owns the host register port.

Sequencer states: `S_IDLE`, `S_FRAME`, `S_RING`, `S_POLL`, `S_FETCH`, `S_ACK`, `S_DONE`, `S_EN_H2C`, `S_EN_C2H`, `S_EN_GATE`, `S_EN_HOLD`. The transitions are as follows:
- `S_IDLE` goes to `S_FRAME` on `seq_start`, or to `S_EN_H2C` on `seq_enable` (start has priority).
- `S_FRAME` stays for five cycles, one per frame word, then goes to `S_RING`.
- `S_RING` goes to `S_POLL`.
- `S_POLL` goes to `S_FETCH` once the return doorbell reads nonzero, or to `S_ACK` after `POLL_LIMIT` polls without a reply.
- `S_FETCH` stays for five cycles and then goes to `S_ACK`.
- `S_ACK` goes to `S_DONE`.
- The enable chain runs `S_EN_H2C` to `S_EN_C2H` to `S_EN_GATE` to `S_EN_HOLD` to `S_DONE`.
- `S_DONE` goes to `S_IDLE`.

Top module: `cpmbx_top`

## Requirements
- R1: After reset the block is in the following state:
  - The control register reads 0x5, with bit 0 (hold) = 1 and bit 2 (gate) = 1.
  - Both doorbells and all message words read 0.
  - `cp_hold` = 1, `cp_gate` = 1, `seq_busy` = 0 and `seq_err` = 0.
- R2: Host map (byte addresses) and access rules:
  - Control is at 0x000, the host-to-coprocessor doorbell at 0x010, the coprocessor-to-host doorbell at 0x014, and message word k at 0x100 + 4k for k = 0..4.
  - In the control register only bits 0 and 2 are stored; all other bits read 0.
  - Unmapped addresses read 0 and ignore writes.
  - `cp_hold` and `cp_gate` follow control bits 0 and 2.
- R3: The coprocessor port reads the host doorbell on `cp_db_h2c` and message word `cp_idx` on `cp_rdata`. It writes message words and the return doorbell. When the host and the coprocessor write the same word or the return doorbell in one cycle, the host value is kept.
- R4: A transaction writes the frame {1, cmd, 1, arg, checksum} to words 0..4 before writing 1 to the host doorbell. The checksum is the 32-bit wrapping sum of words 0..3.
- R5: After ringing, the sequencer polls the return doorbell until it is nonzero. It then reads all five words, presents the returned word 3 on `seq_arg_out`, writes 0 to the return doorbell and pulses `seq_done`.
- R6: A reply code of exactly 1 with a matching returned checksum gives `seq_err` = 0.
- R7: If the returned word 4 differs from the wrapping sum of returned words 0..3, `seq_err` = 5'b00100 whatever the reply code.
- R8: For any other code, `seq_err` has one bit set: the lowest set bit among code bits 0 (bad header), 1 (invalid), 2 (checksum) and 3 (malformed). A code with none of these bits reports bit 3.
- R9: If no nonzero reply arrives within `POLL_LIMIT` polls, `seq_err` = 5'b10000, the return doorbell is still cleared and `seq_arg_out` keeps its previous value.
- R10: `seq_enable` clears the host doorbell, then the return doorbell, then control bit 2, then control bit 0, one step per cycle. `cp_gate` falls exactly one cycle before `cp_hold`, and the sequence ends with a `seq_done` pulse and `seq_err` = 0.
- R11: While `seq_busy` is high, host bus writes and `seq_start` are ignored.
- R12: The following timing holds for the handshake:
  - `seq_busy` rises the cycle after an accepted start.
  - `seq_done` is a one-cycle pulse.
  - `seq_busy` is low the cycle after `seq_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hb_we | input | 1 | Host bus write strobe |
| hb_addr | input | AW | Host bus byte address (write and read) |
| hb_wdata | input | DW | Host bus write data |
| hb_rdata | output | DW | Host bus read data for `hb_addr` (combinational) |
| seq_start | input | 1 | Start a command transaction |
| seq_enable | input | 1 | Start the coprocessor enable sequence |
| seq_cmd | input | DW | Command code for the frame |
| seq_arg | input | DW | Argument 0 for the frame |
| seq_busy | output | 1 | Sequencer active |
| seq_done | output | 1 | One-cycle completion pulse |
| seq_err | output | 5 | Error status: bits 0 header, 1 invalid, 2 checksum, 3 malformed, 4 timeout |
| seq_arg_out | output | DW | Returned frame word 3 |
| cp_hold | output | 1 | Coprocessor held in reset |
| cp_gate | output | 1 | Coprocessor clock gated |
| cp_db_h2c | output | DW | Host-to-coprocessor doorbell value |
| cp_msg_we | input | 1 | Coprocessor message word write |
| cp_idx | input | IW | Coprocessor message word index (read and write) |
| cp_wdata | input | DW | Coprocessor message write data |
| cp_rdata | output | DW | Message word at `cp_idx` |
| cp_db_we | input | 1 | Coprocessor return doorbell write |
| cp_db_wdata | input | DW | Return doorbell write data |

## Verification
A state register that skips or repeats a frame cycle shows up at the coprocessor port as soon as the doorbell rings. The frame words read there are wrong or out of place, so the bench checks all five before it replies. A poll counter or checksum path that misbehaves shows up as a wrong `seq_err` code on the `seq_done` pulse. This happens within a few cycles of the reply, or after exactly `POLL_LIMIT` cycles for a timeout. Misordered enable steps show at the `cp_gate`/`cp_hold` pins inside the four-cycle chain. A broken port handover leaves a stray host write visible in the control register after the transaction.

// File: rtl/cpmbx_pkg.sv
package cpmbx_pkg;

    localparam int unsigned OFF_CTRL = 'h000;
    localparam int unsigned OFF_H2C  = 'h010;
    localparam int unsigned OFF_C2H  = 'h014;
    localparam int unsigned OFF_MSG  = 'h100;

    localparam int unsigned CTL_HOLD = 0;
    localparam int unsigned CTL_GATE = 2;

    localparam int unsigned EB_HDR   = 0;
    localparam int unsigned EB_INVAL = 1;
    localparam int unsigned EB_SUM   = 2;
    localparam int unsigned EB_MALF  = 3;
    localparam int unsigned EB_TMO   = 4;
    localparam int unsigned ERR_W    = 5;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FRAME,
        S_RING,
        S_POLL,
        S_FETCH,
        S_ACK,
        S_DONE,
        S_EN_H2C,
        S_EN_C2H,
        S_EN_GATE,
        S_EN_HOLD
    } seq_state_t;

endpackage

// File: rtl/cpmbx_msgram.sv
module cpmbx_msgram #(
    parameter int unsigned DW    = 32,
    parameter int unsigned WORDS = 5,
    localparam int unsigned IW   = $clog2(WORDS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     h_we,
    input  logic [IW-1:0]            h_idx,
    input  logic [DW-1:0]            h_wd,
    input  logic                     c_we,
    input  logic [IW-1:0]            c_idx,
    input  logic [DW-1:0]            c_wd,
    output logic [WORDS-1:0][DW-1:0] mem_q
);

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else if (h_we && h_idx == IW'(i)) begin
                mem_q[i] <= h_wd;
            end else if (c_we && c_idx == IW'(i)) begin
                mem_q[i] <= c_wd;
            end
        end
    end

    AST_MSG_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && c_we && h_idx == c_idx && h_idx < IW'(WORDS)) |=> mem_q[$past(h_idx)] == $past(h_wd))
        else $error("host write lost to coprocessor write"); // R3

endmodule

// File: rtl/cpmbx_regs.sv
module cpmbx_regs
    import cpmbx_pkg::*;
#(
    parameter int unsigned AW    = 12,
    parameter int unsigned DW    = 32,
    parameter int unsigned WORDS = 5,
    localparam int unsigned IW   = $clog2(WORDS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wen,
    input  logic [AW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [1:0][AW-1:0]       raddr,
    output logic [1:0][DW-1:0]       rdata,
    input  logic                     c_msg_we,
    input  logic [IW-1:0]            c_msg_idx,
    input  logic [DW-1:0]            c_msg_wd,
    input  logic                     c_db_we,
    input  logic [DW-1:0]            c_db_wd,
    output logic                     ctl_hold,
    output logic                     ctl_gate,
    output logic [DW-1:0]            h2c_q,
    output logic [DW-1:0]            c2h_q,
    output logic [WORDS-1:0][DW-1:0] msg_q
);

    function automatic logic msg_hit(input logic [AW-1:0] a);
        return (a >= AW'(OFF_MSG)) && (a < AW'(OFF_MSG + 4 * WORDS)) && (a[1:0] == 2'b00);
    endfunction

    function automatic logic [IW-1:0] msg_idx(input logic [AW-1:0] a);
        logic [AW-1:0] d;
        d = a - AW'(OFF_MSG);
        return d[IW+1:2];
    endfunction

    logic w_ctrl, w_h2c, w_c2h, w_msg;

    always_comb begin
        w_ctrl = wen && waddr == AW'(OFF_CTRL);
        w_h2c  = wen && waddr == AW'(OFF_H2C);
        w_c2h  = wen && waddr == AW'(OFF_C2H);
        w_msg  = wen && msg_hit(waddr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_hold <= 1'b1;
            ctl_gate <= 1'b1;
            h2c_q    <= '0;
            c2h_q    <= '0;
        end else begin
            if (w_ctrl) begin
                ctl_hold <= wdata[CTL_HOLD];
                ctl_gate <= wdata[CTL_GATE];
            end
            if (w_h2c) begin
                h2c_q <= wdata;
            end
            if (w_c2h) begin
                c2h_q <= wdata;
            end else if (c_db_we) begin
                c2h_q <= c_db_wd;
            end
        end
    end

    cpmbx_msgram #(.DW(DW), .WORDS(WORDS)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .h_we  (w_msg),
        .h_idx (msg_idx(waddr)),
        .h_wd  (wdata),
        .c_we  (c_msg_we),
        .c_idx (c_msg_idx),
        .c_wd  (c_msg_wd),
        .mem_q (msg_q)
    );

    for (genvar p = 0; p < 2; p++) begin : g_rport
        always_comb begin
            rdata[p] = '0;
            if (raddr[p] == AW'(OFF_CTRL)) begin
                rdata[p][CTL_HOLD] = ctl_hold;
                rdata[p][CTL_GATE] = ctl_gate;
            end else if (raddr[p] == AW'(OFF_H2C)) begin
                rdata[p] = h2c_q;
            end else if (raddr[p] == AW'(OFF_C2H)) begin
                rdata[p] = c2h_q;
            end else if (msg_hit(raddr[p])) begin
                rdata[p] = msg_q[msg_idx(raddr[p])];
            end
        end
    end

    AST_C2H_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && waddr == AW'(OFF_C2H) && c_db_we) |=> c2h_q == $past(wdata))
        else $error("return doorbell took coprocessor value over host value"); // R3

endmodule

// File: rtl/cpmbx_seq.sv
module cpmbx_seq
    import cpmbx_pkg::*;
#(
    parameter int unsigned AW         = 12,
    parameter int unsigned DW         = 32,
    parameter int unsigned WORDS      = 5,
    parameter int unsigned POLL_LIMIT = 2000,
    localparam int unsigned IW        = $clog2(WORDS),
    localparam int unsigned PCW       = $clog2(POLL_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              enable,
    input  logic [DW-1:0]     cmd,
    input  logic [DW-1:0]     arg,
    input  logic [DW-1:0]     rdata,
    output logic              bus_we,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_wd,
    output logic              busy,
    output logic              done,
    output logic [ERR_W-1:0]  err,
    output logic [DW-1:0]     arg_out
);

    localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

    seq_state_t        state;
    logic [IW-1:0]     idx;
    logic [PCW-1:0]    poll_cnt;
    logic [DW-1:0]     cmd_q, arg_q, resp_q, sum_q, ret_arg_q;
    logic              tmo_q, bad_q;
    logic [ERR_W-1:0]  err_q;

    function automatic logic [DW-1:0] frame_word(input logic [IW-1:0] k,
                                                 input logic [DW-1:0] c,
                                                 input logic [DW-1:0] a);
        unique case (k)
            IW'(0):  return DW'(1);
            IW'(1):  return c;
            IW'(2):  return DW'(1);
            IW'(3):  return a;
            default: return c + a + DW'(2);
        endcase
    endfunction

    function automatic logic [ERR_W-1:0] classify(input logic tmo, input logic bad,
                                                  input logic [DW-1:0] code);
        logic [ERR_W-1:0] e;
        e = '0;
        if (tmo)                   e[EB_TMO]   = 1'b1;
        else if (bad)              e[EB_SUM]   = 1'b1;
        else if (code == DW'(1))   e           = '0;
        else if (code[EB_HDR])     e[EB_HDR]   = 1'b1;
        else if (code[EB_INVAL])   e[EB_INVAL] = 1'b1;
        else if (code[EB_SUM])     e[EB_SUM]   = 1'b1;
        else                       e[EB_MALF]  = 1'b1;
        return e;
    endfunction

    function automatic logic [AW-1:0] msg_addr(input logic [IW-1:0] k);
        return AW'(OFF_MSG) + (AW'(k) << 2);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            idx       <= '0;
            poll_cnt  <= '0;
            cmd_q     <= '0;
            arg_q     <= '0;
            resp_q    <= '0;
            sum_q     <= '0;
            ret_arg_q <= '0;
            tmo_q     <= 1'b0;
            bad_q     <= 1'b0;
            err_q     <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        cmd_q <= cmd;
                        arg_q <= arg;
                        idx   <= '0;
                        tmo_q <= 1'b0;
                        bad_q <= 1'b0;
                        state <= S_FRAME;
                    end else if (enable) begin
                        err_q <= '0;
                        state <= S_EN_H2C;
                    end
                end
                S_FRAME: begin
                    if (idx == LAST) begin
                        state <= S_RING;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_RING: begin
                    poll_cnt <= '0;
                    state    <= S_POLL;
                end
                S_POLL: begin
                    if (rdata != '0) begin
                        resp_q <= rdata;
                        idx    <= '0;
                        sum_q  <= '0;
                        state  <= S_FETCH;
                    end else if (poll_cnt == PCW'(POLL_LIMIT - 1)) begin
                        tmo_q <= 1'b1;
                        state <= S_ACK;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                    end
                end
                S_FETCH: begin
                    if (idx == LAST) begin
                        bad_q <= (rdata != sum_q);
                        state <= S_ACK;
                    end else begin
                        sum_q <= sum_q + rdata;
                        if (idx == IW'(3)) begin
                            ret_arg_q <= rdata;
                        end
                        idx <= idx + 1'b1;
                    end
                end
                S_ACK: begin
                    err_q <= classify(tmo_q, bad_q, resp_q);
                    state <= S_DONE;
                end
                S_EN_H2C:  state <= S_EN_C2H;
                S_EN_C2H:  state <= S_EN_GATE;
                S_EN_GATE: state <= S_EN_HOLD;
                S_EN_HOLD: state <= S_DONE;
                S_DONE:    state <= S_IDLE;
                default:   state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_we   = 1'b0;
        bus_addr = AW'(OFF_C2H);
        bus_wd   = '0;
        unique case (state)
            S_FRAME: begin
                bus_we   = 1'b1;
                bus_addr = msg_addr(idx);
                bus_wd   = frame_word(idx, cmd_q, arg_q);
            end
            S_RING: begin
                bus_we   = 1'b1;
                bus_addr = AW'(OFF_H2C);
                bus_wd   = DW'(1);
            end
            S_FETCH:  bus_addr = msg_addr(idx);
            S_ACK, S_EN_C2H: begin
                bus_we   = 1'b1;
                bus_addr = AW'(OFF_C2H);
            end
            S_EN_H2C: begin
                bus_we   = 1'b1;
                bus_addr = AW'(OFF_H2C);
            end
            S_EN_GATE: begin
                bus_we   = 1'b1;
                bus_addr = AW'(OFF_CTRL);
                bus_wd   = rdata & ~(DW'(1) << CTL_GATE);
            end
            S_EN_HOLD: begin
                bus_we   = 1'b1;
                bus_addr = AW'(OFF_CTRL);
                bus_wd   = rdata & ~(DW'(1) << CTL_HOLD);
            end
            default: ;
        endcase
        busy    = (state != S_IDLE);
        done    = (state == S_DONE);
        err     = err_q;
        arg_out = ret_arg_q;
    end

    AST_ERR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot0(err))
        else $error("more than one error bit reported"); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy)
        else $error("done not a single pulse"); // R12

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy)
        else $error("start accepted without busy"); // R12

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_POLL) |-> (poll_cnt < PCW'(POLL_LIMIT)))
        else $error("poll counter beyond limit"); // R9

endmodule

// File: rtl/cpmbx_top.sv
module cpmbx_top
    import cpmbx_pkg::*;
#(
    parameter int unsigned AW         = 12,
    parameter int unsigned DW         = 32,
    parameter int unsigned WORDS      = 5,
    parameter int unsigned POLL_LIMIT = 2000,
    localparam int unsigned IW        = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hb_we,
    input  logic [AW-1:0]     hb_addr,
    input  logic [DW-1:0]     hb_wdata,
    output logic [DW-1:0]     hb_rdata,
    input  logic              seq_start,
    input  logic              seq_enable,
    input  logic [DW-1:0]     seq_cmd,
    input  logic [DW-1:0]     seq_arg,
    output logic              seq_busy,
    output logic              seq_done,
    output logic [ERR_W-1:0]  seq_err,
    output logic [DW-1:0]     seq_arg_out,
    output logic              cp_hold,
    output logic              cp_gate,
    output logic [DW-1:0]     cp_db_h2c,
    input  logic              cp_msg_we,
    input  logic [IW-1:0]     cp_idx,
    input  logic [DW-1:0]     cp_wdata,
    output logic [DW-1:0]     cp_rdata,
    input  logic              cp_db_we,
    input  logic [DW-1:0]     cp_db_wdata
);

    logic                     s_we;
    logic [AW-1:0]            s_addr;
    logic [DW-1:0]            s_wd;
    logic                     m_we;
    logic [AW-1:0]            m_addr;
    logic [DW-1:0]            m_wd;
    logic [1:0][AW-1:0]       raddr;
    logic [1:0][DW-1:0]       rdata;
    logic [DW-1:0]            c2h_q;
    logic [WORDS-1:0][DW-1:0] msg_q;

    always_comb begin
        m_we     = seq_busy ? s_we   : hb_we;
        m_addr   = seq_busy ? s_addr : hb_addr;
        m_wd     = seq_busy ? s_wd   : hb_wdata;
        raddr[0] = hb_addr;
        raddr[1] = s_addr;
        hb_rdata = rdata[0];
        cp_rdata = (cp_idx < IW'(WORDS)) ? msg_q[cp_idx] : '0;
    end

    cpmbx_regs #(.AW(AW), .DW(DW), .WORDS(WORDS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wen       (m_we),
        .waddr     (m_addr),
        .wdata     (m_wd),
        .raddr     (raddr),
        .rdata     (rdata),
        .c_msg_we  (cp_msg_we),
        .c_msg_idx (cp_idx),
        .c_msg_wd  (cp_wdata),
        .c_db_we   (cp_db_we),
        .c_db_wd   (cp_db_wdata),
        .ctl_hold  (cp_hold),
        .ctl_gate  (cp_gate),
        .h2c_q     (cp_db_h2c),
        .c2h_q     (c2h_q),
        .msg_q     (msg_q)
    );

    cpmbx_seq #(.AW(AW), .DW(DW), .WORDS(WORDS), .POLL_LIMIT(POLL_LIMIT)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (seq_start),
        .enable   (seq_enable),
        .cmd      (seq_cmd),
        .arg      (seq_arg),
        .rdata    (rdata[1]),
        .bus_we   (s_we),
        .bus_addr (s_addr),
        .bus_wd   (s_wd),
        .busy     (seq_busy),
        .done     (seq_done),
        .err      (seq_err),
        .arg_out  (seq_arg_out)
    );

    AST_GATE_BEFORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cp_hold) && seq_busy) |-> (!cp_gate && $past(!cp_gate)))
        else $error("hold released before clock ungated"); // R10

endmodule

// File: tb/sim_cpmbx_top.sv
module sim_cpmbx_top;

    localparam int AW = 12;
    localparam int DW = 32;
    localparam int WORDS = 5;
    localparam int IW = 3;
    localparam int PL = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hb_we = 1'b0;
    logic [AW-1:0] hb_addr = '0;
    logic [DW-1:0] hb_wdata = '0;
    logic [DW-1:0] hb_rdata;
    logic seq_start = 1'b0, seq_enable = 1'b0;
    logic [DW-1:0] seq_cmd = '0, seq_arg = '0;
    logic seq_busy, seq_done;
    logic [4:0] seq_err;
    logic [DW-1:0] seq_arg_out;
    logic cp_hold, cp_gate;
    logic [DW-1:0] cp_db_h2c;
    logic cp_msg_we = 1'b0;
    logic [IW-1:0] cp_idx = '0;
    logic [DW-1:0] cp_wdata = '0;
    logic [DW-1:0] cp_rdata;
    logic cp_db_we = 1'b0;
    logic [DW-1:0] cp_db_wdata = '0;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] last_arg = '0;

    always #5 clk = ~clk;

    cpmbx_top #(.AW(AW), .DW(DW), .WORDS(WORDS), .POLL_LIMIT(PL)) u0 (
        .clk(clk), .rst_n(rst_n),
        .hb_we(hb_we), .hb_addr(hb_addr), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
        .seq_start(seq_start), .seq_enable(seq_enable), .seq_cmd(seq_cmd), .seq_arg(seq_arg),
        .seq_busy(seq_busy), .seq_done(seq_done), .seq_err(seq_err), .seq_arg_out(seq_arg_out),
        .cp_hold(cp_hold), .cp_gate(cp_gate), .cp_db_h2c(cp_db_h2c),
        .cp_msg_we(cp_msg_we), .cp_idx(cp_idx), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
        .cp_db_we(cp_db_we), .cp_db_wdata(cp_db_wdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
        hb_we = 1'b1; hb_addr = a; hb_wdata = d;
        @(negedge clk);
        hb_we = 1'b0;
    endtask

    task automatic hread(input logic [AW-1:0] a, output logic [DW-1:0] d);
        hb_addr = a;
        #1;
        d = hb_rdata;
    endtask

    function automatic logic [4:0] exp_err(input bit tmo, input bit bad, input logic [DW-1:0] c);
        if (tmo) return 5'h10;
        if (bad) return 5'h04;
        if (c == 32'd1) return 5'h00;
        if (c[0]) return 5'h01;
        if (c[1]) return 5'h02;
        if (c[2]) return 5'h04;
        return 5'h08;
    endfunction

    task automatic run_txn(input logic [DW-1:0] cmd, input logic [DW-1:0] arg,
                           input bit respond, input logic [DW-1:0] code,
                           input bit corrupt, input logic [DW-1:0] rarg,
                           input int delay, input string tag);
        logic [DW-1:0] w [5];
        logic [DW-1:0] d;
        bit ok;
        bit seen;
        int n;
        hwrite(12'h010, 32'h0);
        seq_cmd = cmd; seq_arg = arg; seq_start = 1'b1;
        @(negedge clk);
        seq_start = 1'b0;
        chk(seq_busy == 1'b1, {"R12 busy after start ", tag}, {31'b0, seq_busy}, 32'h1);
        if (respond) begin
            n = 0;
            while (cp_db_h2c != 32'h1 && n < 50) begin @(negedge clk); n++; end
            w[0] = 32'h1; w[1] = cmd; w[2] = 32'h1; w[3] = arg; w[4] = cmd + arg + 32'h2;
            ok = (n < 50);
            for (int k = 0; k < 5; k++) begin
                cp_idx = IW'(k); #1;
                if (cp_rdata != w[k]) begin
                    ok = 1'b0;
                    $display("FAIL R4 frame word %0d actual=0x%08h expected=0x%08h", k, cp_rdata, w[k]);
                end
            end
            chk(ok, {"R4 frame ", tag}, {31'b0, ok}, 32'h1);
            repeat (delay) @(negedge clk);
            w[0] = 32'h2; w[1] = cmd; w[2] = 32'h1; w[3] = rarg;
            w[4] = w[0] + w[1] + w[2] + w[3] + (corrupt ? 32'h1 : 32'h0);
            for (int k = 0; k < 5; k++) begin
                cp_msg_we = 1'b1; cp_idx = IW'(k); cp_wdata = w[k];
                @(negedge clk);
            end
            cp_msg_we = 1'b0;
            cp_db_we = 1'b1; cp_db_wdata = code;
            @(negedge clk);
            cp_db_we = 1'b0;
        end
        n = 0; seen = 1'b0;
        while (n < PL + 100) begin
            if (seq_done) begin seen = 1'b1; break; end
            @(negedge clk); n++;
        end
        chk(seen, {"R5 done seen ", tag}, {31'b0, seen}, 32'h1);
        d = {27'b0, exp_err(!respond, corrupt, code)};
        chk(seq_err == d[4:0], {"R6/R7/R8/R9 err ", tag}, {27'b0, seq_err}, d);
        if (respond) last_arg = rarg;
        chk(seq_arg_out == last_arg, {"R5/R9 arg_out ", tag}, seq_arg_out, last_arg);
        @(negedge clk);
        chk(!seq_busy && !seq_done, {"R12 idle after done ", tag}, {30'b0, seq_busy, seq_done}, 32'h0);
        hread(12'h014, d);
        chk(d == 32'h0, {"R5/R9 return doorbell cleared ", tag}, d, 32'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] d;
        int tg, th;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        hread(12'h000, d); chk(d == 32'h5, "R1 ctrl reset", d, 32'h5);
        hread(12'h010, d); chk(d == 32'h0, "R1 h2c reset", d, 32'h0);
        hread(12'h014, d); chk(d == 32'h0, "R1 c2h reset", d, 32'h0);
        for (int k = 0; k < WORDS; k++) begin
            hread(AW'(12'h100 + 4 * k), d); chk(d == 32'h0, "R1 msg reset", d, 32'h0);
        end
        chk(cp_hold && cp_gate && !seq_busy && seq_err == 5'h0, "R1 outputs reset",
            {27'b0, cp_hold, cp_gate, seq_busy, 2'b0}, 32'h18);

        // R2 register map
        hwrite(12'h000, 32'hFFFF_FFFF);
        hread(12'h000, d); chk(d == 32'h5, "R2 ctrl stored bits", d, 32'h5);
        hwrite(12'h000, 32'h0000_0001);
        chk(cp_hold && !cp_gate, "R2 hold/gate pins", {30'b0, cp_hold, cp_gate}, 32'h2);
        hwrite(12'h000, 32'h5);
        hwrite(12'h020, 32'hDEAD_BEEF);
        hread(12'h020, d); chk(d == 32'h0, "R2 unmapped reads zero", d, 32'h0);
        hread(12'h114, d); chk(d == 32'h0, "R2 past last word reads zero", d, 32'h0);
        hwrite(12'h10C, 32'h1234_5678);
        cp_idx = 3'd3; #1;
        chk(cp_rdata == 32'h1234_5678, "R2 R3 host msg write seen by cp", cp_rdata, 32'h1234_5678);

        // R3 cp writes and same-cycle priority
        hwrite(12'h010, 32'hA5);
        chk(cp_db_h2c == 32'hA5, "R3 cp sees h2c", cp_db_h2c, 32'hA5);
        hb_we = 1'b1; hb_addr = 12'h104; hb_wdata = 32'h1111_1111;
        cp_msg_we = 1'b1; cp_idx = 3'd1; cp_wdata = 32'h2222_2222;
        @(negedge clk);
        hb_we = 1'b0; cp_msg_we = 1'b0;
        hread(12'h104, d); chk(d == 32'h1111_1111, "R3 msg host wins", d, 32'h1111_1111);
        cp_msg_we = 1'b1; cp_idx = 3'd2; cp_wdata = 32'h3333_0000;
        @(negedge clk);
        cp_msg_we = 1'b0;
        hread(12'h108, d); chk(d == 32'h3333_0000, "R3 cp msg write", d, 32'h3333_0000);
        hb_we = 1'b1; hb_addr = 12'h014; hb_wdata = 32'h0;
        cp_db_we = 1'b1; cp_db_wdata = 32'h77;
        @(negedge clk);
        hb_we = 1'b0; cp_db_we = 1'b0;
        hread(12'h014, d); chk(d == 32'h0, "R3 doorbell host wins", d, 32'h0);

        // directed transactions
        run_txn(32'h1, 32'h1, 1'b1, 32'h1, 1'b0, 32'hCAFE_0001, 0, "success");
        run_txn(32'hFFFF_FFFF, 32'h3, 1'b1, 32'h1, 1'b1, 32'h44, 2, "R7 bad sum with success");
        run_txn(32'h2, 32'h2, 1'b1, 32'h8000_0006, 1'b0, 32'h55, 1, "R8 multi bit code");
        run_txn(32'h2, 32'h2, 1'b1, 32'h8000_0000, 1'b0, 32'h66, 0, "R8 no known bit");
        run_txn(32'h3, 32'h9, 1'b1, 32'h8000_0004, 1'b1, 32'h67, 0, "R7 bad sum with error");

        // R9 timeout
        run_txn(32'h4, 32'h4, 1'b0, 32'h0, 1'b0, 32'h0, 0, "R9 timeout");

        // R11 writes and start ignored while busy
        hread(12'h000, d); chk(d == 32'h5, "R11 ctrl before", d, 32'h5);
        seq_cmd = 32'h7; seq_arg = 32'h8; seq_start = 1'b1;
        @(negedge clk);
        seq_start = 1'b0;
        hwrite(12'h000, 32'h0);
        seq_start = 1'b1;
        @(negedge clk);
        seq_start = 1'b0;
        tg = 0;
        while (!seq_done && tg < PL + 50) begin @(negedge clk); tg++; end
        @(negedge clk);
        chk(!seq_busy, "R11 second start ignored", {31'b0, seq_busy}, 32'h0);
        hread(12'h000, d); chk(d == 32'h5, "R11 host write ignored while busy", d, 32'h5);

        // random transactions
        for (int t = 0; t < 16; t++) begin
            logic [DW-1:0] code;
            int sel;
            sel = int'($urandom_range(0, 7));
            case (sel)
                0, 1: code = 32'h1;
                2: code = 32'h8000_0001;
                3: code = 32'h8000_0002;
                4: code = 32'h8000_0004;
                5: code = 32'h8000_0008;
                6: code = 32'h8000_000C;
                default: code = 32'h0000_0020;
            endcase
            run_txn($urandom, $urandom, 1'b1, code, ($urandom_range(0, 3) == 0),
                    $urandom, int'($urandom_range(0, 40)), "random R6 R8");
        end

        // R10 enable sequence
        hwrite(12'h010, 32'h7);
        hwrite(12'h014, 32'h9);
        seq_enable = 1'b1;
        @(negedge clk);
        seq_enable = 1'b0;
        tg = -1; th = -1;
        for (int c = 0; c < 10; c++) begin
            if (tg < 0 && !cp_gate) begin
                tg = c;
                hread(12'h014, d);
                chk(cp_db_h2c == 32'h0 && d == 32'h0 && cp_hold, "R10 doorbells cleared first",
                    cp_db_h2c | d, 32'h0);
            end
            if (th < 0 && !cp_hold) th = c;
            if (seq_done) chk(seq_err == 5'h0, "R10 err zero", {27'b0, seq_err}, 32'h0);
            @(negedge clk);
        end
        chk(tg >= 0 && th == tg + 1, "R10 gate one cycle before hold", th, tg + 1);
        hread(12'h000, d); chk(d == 32'h0, "R10 ctrl cleared", d, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule